// File: doc/BRIEF.md
# Seven-to-One Three-Lane Serializer with Forwarded Clock

The block accepts a parallel word once per period of a word-rate clock and sends it out over a set of narrow serial lanes. Each lane carries one slice of the word. It sends one bit per period of a bit-rate clock that runs seven times faster and is phase-aligned to the word clock. That bit-rate clock comes from outside the block, so the block models no clock synthesis. A separate lane carries a forwarded clock pattern. The far end uses its rising transition to find the start of each word. With the default parameters there are three data lanes and seven slots each, which gives a 21-bit word.

An active-low power-down input switches the whole transmitter off. While it is low, the pad-enable output is low, which tells the pad drivers to float, and every serial output is held at zero. When power-down is released, the transmitter waits a fixed number of bit-clock cycles before it enables the pads. This wait stands in for the time the clock source needs to settle, which is 10 ms in a real system. If the word clock ever stops, the system must hold power-down low until that clock is running again. The next release then restarts this wait from zero.

Top module: `lvds7_ser_tx`

## Requirements
- R1: The word on `par_data_i` is sampled only on the rising edge of `clk_word_i`. Changes between those edges have no effect on what is sent.
- R2: Lane j of `ser_data_o` carries word bits 7j to 7j+6. Lane 0 carries bits 0..6, lane 1 carries bits 7..13 and lane 2 carries bits 14..20.
- R3: Within a lane, the lowest-numbered bit is sent first. Slot s of a word carries bit 7j+s of that word on lane j, and each slot lasts one `clk_bit_i` period.
- R4: Slot 0 of a word captured at a word-clock edge appears on the serial outputs after the next `clk_bit_i` rising edge. The seven slots follow on consecutive bit-clock edges, back to back with the next word.
- R5: `ser_clk_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6, so that its only rising transition marks slot 0.
- R6: When `pwr_up_n_i` is sampled low at a bit-clock edge, `pad_oe_o` is 0 after that edge. It stays 0 for as long as `pwr_up_n_i` stays low.
- R7: After `pwr_up_n_i` returns high, `pad_oe_o` becomes 1 after exactly LOCK_CYCLES bit-clock edges sampled with `pwr_up_n_i` high. It is still 0 after LOCK_CYCLES-1 of those edges.
- R8: While `rst_i` is high, `pad_oe_o` is 0 and the serial outputs are 0. After `rst_i` is released, the settle wait of R7 starts from zero.
- R9: Whenever `pad_oe_o` is 0, `ser_data_o` and `ser_clk_o` are 0.
- R10: If `pwr_up_n_i` drops during the settle wait, the wait is abandoned. The next release waits the full LOCK_CYCLES again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word_i | input | 1 | Word-rate clock; its rising edge strobes the parallel word |
| clk_bit_i | input | 1 | Bit-rate clock, 7x the word clock, rising edges aligned |
| rst_i | input | 1 | Synchronous active-high reset, for both clock domains |
| pwr_up_n_i | input | 1 | Active-low power-down |
| par_data_i | input | 21 | Parallel word |
| ser_data_o | output | 3 | Serial data lanes |
| ser_clk_o | output | 1 | Forwarded clock lane |
| pad_oe_o | output | 1 | Pad drive enable; 0 means the pad drivers float |

## Verification
A slot counter that is off by one shifts every recovered bit by one position. A lost or doubled load shows up as a whole word repeated or skipped. In both cases the next word already reads back wrong at the ports, and the clock-lane rise no longer lines up with bit 0. A settle counter that miscounts moves the rise of `pad_oe_o` by a cycle or more. A power-down that fails to clear the count lets the pads enable early on a second release. Both are visible within one settle interval.

// File: rtl/lvds7_ser_pkg.sv
package lvds7_ser_pkg;

    // Power sequencing states of the transmitter.
    typedef enum logic [1:0] {
        PWR_OFF    = 2'd0,
        PWR_SETTLE = 2'd1,
        PWR_LIVE   = 2'd2
    } pwr_state_e;

    // Level of the forwarded clock lane in a given slot.
    function automatic logic fwd_clk_level(input int unsigned slot,
                                           input int unsigned high_slots);
        return (slot < high_slots);
    endfunction

endpackage

// File: rtl/lvds7_ser_capture.sv
module lvds7_ser_capture #(
    parameter int unsigned WORD_W = 21
) (
    input  logic              clk_word_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              tog_o
);
    // Word register plus a toggle that announces each new capture to the bit domain.
    always_ff @(posedge clk_word_i) begin
        if (rst_i) begin
            word_o <= '0;
            tog_o  <= 1'b0;
        end else begin
            word_o <= word_i;
            tog_o  <= ~tog_o;
        end
    end
endmodule

// File: rtl/lvds7_ser_pwr_seq.sv
module lvds7_ser_pwr_seq
    import lvds7_ser_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 850000
) (
    input  logic clk_bit_i,
    input  logic rst_i,
    input  logic pwr_up_n_i,
    output logic oe_o
);
    localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LOCK_CYCLES);

    pwr_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + 1'b1;

    always_ff @(posedge clk_bit_i) begin
        if (rst_i || !pwr_up_n_i) begin
            st_q  <= PWR_OFF;
            cnt_q <= '0;
        end else begin
            case (st_q)
                PWR_OFF, PWR_SETTLE: begin
                    cnt_q <= cnt_nx;
                    st_q  <= (cnt_nx == CNT_END) ? PWR_LIVE : PWR_SETTLE;
                end
                default: begin
                    st_q <= PWR_LIVE;
                end
            endcase
        end
    end

    assign oe_o = (st_q == PWR_LIVE);

    AST_PDN_FORCES_OFF: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        !pwr_up_n_i |=> !oe_o); // R6

    AST_ENABLE_NEEDS_PWR: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        $rose(oe_o) |-> $past(pwr_up_n_i)); // R7

    AST_STATE_LEGAL: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        st_q != 2'd3); // R7
endmodule

// File: rtl/lvds7_ser_lanes.sv
module lvds7_ser_lanes #(
    parameter int unsigned LANES = 3,
    parameter int unsigned SLOTS = 7
) (
    input  logic                    clk_bit_i,
    input  logic                    rst_i,
    input  logic                    load_i,
    input  logic [LANES*SLOTS-1:0]  word_i,
    output logic [LANES-1:0]        lane_o
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [SLOTS-1:0] sh_q;
            always_ff @(posedge clk_bit_i) begin
                if (rst_i) begin
                    sh_q <= '0;
                end else if (load_i) begin
                    sh_q <= word_i[g*SLOTS +: SLOTS];
                end else begin
                    sh_q <= {1'b0, sh_q[SLOTS-1:1]};
                end
            end
            assign lane_o[g] = sh_q[0];
        end
    endgenerate
endmodule

// File: rtl/lvds7_ser_clk_lane.sv
module lvds7_ser_clk_lane
    import lvds7_ser_pkg::*;
#(
    parameter int unsigned SLOTS      = 7,
    parameter int unsigned HIGH_SLOTS = 4
) (
    input  logic clk_bit_i,
    input  logic rst_i,
    input  logic load_i,
    output logic clk_o
);
    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk_bit_i) begin
        if (rst_i || load_i) begin
            slot_q <= '0;
        end else begin
            slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
        end
    end

    assign clk_o = fwd_clk_level(int'(slot_q), HIGH_SLOTS);

    AST_SLOT_BOUND: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        slot_q <= SLOT_LAST); // R5
endmodule

// File: rtl/lvds7_ser_tx.sv
module lvds7_ser_tx #(
    parameter int unsigned LANES       = 3,
    parameter int unsigned SLOTS       = 7,
    parameter int unsigned HIGH_SLOTS  = 4,
    parameter int unsigned LOCK_CYCLES = 850000,
    localparam int unsigned WORD_W     = LANES * SLOTS
) (
    input  logic              clk_word_i,
    input  logic              clk_bit_i,
    input  logic              rst_i,
    input  logic              pwr_up_n_i,
    input  logic [WORD_W-1:0] par_data_i,
    output logic [LANES-1:0]  ser_data_o,
    output logic              ser_clk_o,
    output logic              pad_oe_o
);
    logic [WORD_W-1:0] word_q;
    logic              tog_w;
    logic              tog_seen_q;
    logic              load;
    logic [LANES-1:0]  lane_raw;
    logic              clk_raw;
    logic              oe;
    logic [LANES-1:0]  first_bits;

    lvds7_ser_capture #(.WORD_W(WORD_W)) u_capture (
        .clk_word_i (clk_word_i),
        .rst_i      (rst_i),
        .word_i     (par_data_i),
        .word_o     (word_q),
        .tog_o      (tog_w)
    );

    // A new capture shows as a toggle mismatch; load on the following bit edge.
    always_ff @(posedge clk_bit_i) begin
        if (rst_i) tog_seen_q <= 1'b0;
        else       tog_seen_q <= tog_w;
    end
    assign load = (tog_w != tog_seen_q);

    lvds7_ser_lanes #(.LANES(LANES), .SLOTS(SLOTS)) u_lanes (
        .clk_bit_i (clk_bit_i),
        .rst_i     (rst_i),
        .load_i    (load),
        .word_i    (word_q),
        .lane_o    (lane_raw)
    );

    lvds7_ser_clk_lane #(.SLOTS(SLOTS), .HIGH_SLOTS(HIGH_SLOTS)) u_clk_lane (
        .clk_bit_i (clk_bit_i),
        .rst_i     (rst_i),
        .load_i    (load),
        .clk_o     (clk_raw)
    );

    lvds7_ser_pwr_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_pwr (
        .clk_bit_i  (clk_bit_i),
        .rst_i      (rst_i),
        .pwr_up_n_i (pwr_up_n_i),
        .oe_o       (oe)
    );

    assign ser_data_o = oe ? lane_raw : '0;
    assign ser_clk_o  = oe & clk_raw;
    assign pad_oe_o   = oe;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_first
            assign first_bits[g] = word_q[g*SLOTS];
        end
    endgenerate

    AST_LOAD_SPACED: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        load |=> !load); // R4

    AST_FIRST_SLOT_BITS: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        load |=> (lane_raw == $past(first_bits))); // R3

    AST_CLK_MARKS_WORD: assert property (@(posedge clk_bit_i) disable iff (rst_i)
        load |=> clk_raw); // R5
endmodule

// File: tb/lvds7_ser_tx_bench.sv
module lvds7_ser_tx_bench;
    localparam int unsigned LANES = 3;
    localparam int unsigned SLOTS = 7;
    localparam int unsigned LOCK  = 40;
    localparam int unsigned WW    = LANES * SLOTS;

    logic          clk_word = 1'b0;
    logic          clk_bit  = 1'b0;
    logic          rst      = 1'b1;
    logic          pwr_up_n = 1'b1;
    logic [WW-1:0] din      = '0;
    logic [LANES-1:0] ser_data;
    logic          ser_clk;
    logic          pad_oe;

    int ph = 6;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    lvds7_ser_tx #(.LANES(LANES), .SLOTS(SLOTS), .HIGH_SLOTS(4), .LOCK_CYCLES(LOCK))
    u_lvds7_ser_tx (
        .clk_word_i (clk_word),
        .clk_bit_i  (clk_bit),
        .rst_i      (rst),
        .pwr_up_n_i (pwr_up_n),
        .par_data_i (din),
        .ser_data_o (ser_data),
        .ser_clk_o  (ser_clk),
        .pad_oe_o   (pad_oe)
    );

    // 50 MHz bit clock; word clock at one seventh, rising edges aligned.
    initial begin
        forever begin
            #10;
            ph = (ph == 6) ? 0 : ph + 1;
            if (ph == 0) clk_word = 1'b1;
            if (ph == 4) clk_word = 1'b0;
            clk_bit = 1'b1;
            #10;
            clk_bit = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Stimulus words: directed corners first, then seeded random.
    int unsigned widx = 0;
    function automatic logic [WW-1:0] next_word(input int unsigned i);
        logic [WW-1:0] w;
        if (i == 0)       w = '1;
        else if (i == 1)  w = '0;
        else if (i == 2)  w = WW'(21'h155555);
        else if (i == 3)  w = WW'(21'h0AAAAA);
        else if (i < 4 + WW) w = WW'(1) << (i - 4);   // walking one, R2 lane mapping
        else              w = WW'($urandom());
        return w;
    endfunction

    // Monitor and data driver, away from the active edge.
    logic [WW-1:0] w_cur = '0;
    logic [WW-1:0] w_prev = '0;
    int px_seen = 0;
    initial begin
        void'($urandom(32'd20240611));
        forever begin
            @(negedge clk_bit);
            if (ph == 0) begin
                if (rst) begin
                    w_cur = '0; w_prev = '0; px_seen = 0;
                end else begin
                    w_prev = w_cur; w_cur = din; px_seen++;
                end
            end
            if (!pad_oe) begin
                // R9: outputs quiet while pads are disabled
                chk(ser_data == '0 && ser_clk == 1'b0, "R9 quiet outputs",
                    int'({ser_clk, ser_data}), 0);
            end else if (px_seen >= 2 && !rst) begin
                int s;
                logic [WW-1:0] w;
                logic [LANES-1:0] exp_d;
                s = (ph == 0) ? 6 : ph - 1;
                w = (ph == 0) ? w_prev : w_cur;
                for (int j = 0; j < LANES; j++) exp_d[j] = w[j*SLOTS + s];
                // R1 R2 R3 R4 serial data per slot
                chk(ser_data == exp_d, "R1 R2 R3 R4 lane bits", int'(ser_data), int'(exp_d));
                // R5 forwarded clock level per slot
                chk(ser_clk == (s < 4), "R5 clock lane", int'(ser_clk), int'(s < 4));
            end
            if (ph == 6) begin
                din = next_word(widx);
                widx++;
            end else begin
                din = WW'($urandom());   // R1: noise between strobes
            end
        end
    end

    task automatic wait_pos(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_bit);
    endtask

    initial begin
        wait_pos(20);
        do @(negedge clk_bit); while (ph != 3);
        // R8: reset state
        chk(pad_oe == 1'b0, "R8 pad enable in reset", int'(pad_oe), 0);
        chk(ser_data == '0 && ser_clk == 1'b0, "R8 outputs in reset", int'({ser_clk, ser_data}), 0);
        rst = 1'b0;
        // R7 / R8: settle counted from reset release
        wait_pos(LOCK - 1);
        @(negedge clk_bit);
        chk(pad_oe == 1'b0, "R8 R7 enable one edge early", int'(pad_oe), 0);
        wait_pos(1);
        @(negedge clk_bit);
        chk(pad_oe == 1'b1, "R8 R7 enable at count", int'(pad_oe), 1);

        wait_pos(400);
        // R6: power-down
        @(negedge clk_bit);
        pwr_up_n = 1'b0;
        wait_pos(1);
        @(negedge clk_bit);
        chk(pad_oe == 1'b0, "R6 off after power-down edge", int'(pad_oe), 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_bit);
            chk(pad_oe == 1'b0, "R6 stays off", int'(pad_oe), 0);
        end

        // R10: aborted settle restarts
        pwr_up_n = 1'b1;
        wait_pos(LOCK / 2);
        @(negedge clk_bit);
        chk(pad_oe == 1'b0, "R10 still settling", int'(pad_oe), 0);
        pwr_up_n = 1'b0;
        wait_pos(3);
        @(negedge clk_bit);
        pwr_up_n = 1'b1;
        wait_pos(LOCK - 1);
        @(negedge clk_bit);
        chk(pad_oe == 1'b0, "R10 R7 full wait again", int'(pad_oe), 0);
        wait_pos(1);
        @(negedge clk_bit);
        chk(pad_oe == 1'b1, "R10 R7 enable after full wait", int'(pad_oe), 1);

        wait_pos(1500);
        finish_run();
    end

    // Watchdog
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk_bit);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end
endmodule